// File: doc/BRIEF.md
# Tagged Add/Subtract Unit with Overflow Trap

This unit executes tagged-integer addition and subtraction on two 32-bit operands. The two least significant bits of each operand are a type tag, and a tagged operand is only valid when its tag is zero. The unit raises a trap when either operand has a nonzero tag. It also raises a trap when the signed 32-bit operation overflows. A trap is one pulse, even when both conditions are present.

When an operation does not trap, the unit delivers the result with a valid pulse. It also writes new N, Z, V and C condition flags into a held 4-bit register. When an operation traps, no result is produced and the flags keep their previous value. All outputs are registered and appear one clock after the accepted operation.

Top module: `tagged_arith`

## Requirements
- R1: After reset, `res_valid`, `trap`, `cc_we`, `res_data` and `flags` are all zero.
- R2: A non-trapping add (`op_sub`=0) presented with `op_valid` gives `res_data` = (`opa`+`opb`) mod 2^32 with `res_valid` high on the next cycle.
- R3: A non-trapping subtract (`op_sub`=1) gives `res_data` = (`opa`-`opb`) mod 2^32 with `res_valid` high on the next cycle.
- R4: If bit 0 or bit 1 of either operand is set, `trap` pulses on the next cycle and `res_valid` stays low.
- R5: An add whose signed 32-bit result overflows traps.
- R6: A subtract whose signed 32-bit result overflows traps.
- R7: A trapping operation leaves `flags` unchanged and keeps `cc_we` low.
- R8: `flags` bit 3 (N) is result bit 31 and `flags` bit 2 (Z) is 1 exactly when the result is zero. Both are loaded with `cc_we` high on the cycle after a non-trapping operation.
- R9: `flags` bit 1 (V) is 0 after every non-trapping operation. `flags` bit 0 (C) is the unsigned carry out of an add, or 1 for a subtract when `opa` < `opb` unsigned.
- R10: `trap` and `res_valid` are never high together. Both are single-cycle pulses that occur only in the cycle after `op_valid`. `cc_we` equals `res_valid`.
- R11: An operation with both a tag fault and an arithmetic overflow gives exactly one `trap` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_sub | input | 1 | 1 selects subtract, 0 selects add |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| res_valid | output | 1 | Result-valid pulse |
| res_data | output | 32 | Result, held between operations |
| cc_we | output | 1 | Condition-flag write pulse |
| flags | output | 4 | Held flags {N,Z,V,C} |
| trap | output | 1 | Tag-overflow trap pulse |

## Verification
Clean-tag operands are tried at small magnitudes, around zero, and with large unsigned values. These separate the carry and borrow logic from the signed overflow logic, and they produce zero results for the Z flag. Operands near ±2^31 are applied in both directions. A positive-into-negative wrap, a negative-into-positive wrap, and the near miss just below each show whether the add and subtract overflow terms are chosen correctly. Each tag bit is set alone and then in combination with an overflow. This shows the tag check covers both bits of both operands, gives a single trap pulse, and leaves the flags untouched. Idle cycles placed between operations show that no pulse appears without a strobe.

// File: rtl/tagged_arith.sv
module tagged_arith #(
  parameter int WIDTH = 32,
  parameter int TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic             op_sub,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic             res_valid,
  output logic [WIDTH-1:0] res_data,
  output logic             cc_we,
  output logic [3:0]       flags,
  output logic             trap
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   sum;
  logic [WIDTH-1:0] result;
  logic [WIDTH-1:0] same_sign, diff_sign, sign_flip;
  logic             tag_bad, ovf, carry, fault, ok;

  assign b_eff     = op_sub ? ~opb : opb;
  assign sum       = {1'b0, opa} + {1'b0, b_eff} + {{WIDTH{1'b0}}, op_sub};
  assign result    = sum[MSB:0];
  assign carry     = op_sub ? ~sum[WIDTH] : sum[WIDTH];

  assign same_sign = ~(opa ^ opb);
  assign diff_sign = opa ^ opb;
  assign sign_flip = opa ^ result;
  assign ovf       = op_sub ? (diff_sign[MSB] & sign_flip[MSB])
                            : (same_sign[MSB] & sign_flip[MSB]);

  assign tag_bad   = |(opa[TAG_W-1:0] | opb[TAG_W-1:0]);
  assign fault     = tag_bad | ovf;
  assign ok        = op_valid & ~fault;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      cc_we     <= 1'b0;
      trap      <= 1'b0;
      res_data  <= '0;
      flags     <= 4'b0000;
    end else begin
      res_valid <= ok;
      cc_we     <= ok;
      trap      <= op_valid & fault;
      if (ok) begin
        res_data <= result;
        flags    <= {result[MSB], ~|result, 1'b0, carry};
      end
    end
  end
endmodule

// File: rtl/tagged_arith_chk.sv
module tagged_arith_chk #(
  parameter int WIDTH = 32,
  parameter int TAG_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic             res_valid,
  input logic [WIDTH-1:0] res_data,
  input logic             cc_we,
  input logic [3:0]       flags,
  input logic             trap
);
  // R10
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap && res_valid));

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!res_valid && !trap && !cc_we));

  // R4
  tag_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && |(opa[TAG_W-1:0] | opb[TAG_W-1:0])) |=> (trap && !res_valid));

  // R7
  hold_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> ($stable(flags) && !cc_we));

  // R9
  no_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !flags[1]);

  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (flags[2] == (res_data == '0) && flags[3] == res_data[WIDTH-1]));
endmodule

bind tagged_arith tagged_arith_chk #(.WIDTH(WIDTH), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opa(opa), .opb(opb),
  .res_valid(res_valid), .res_data(res_data), .cc_we(cc_we),
  .flags(flags), .trap(trap)
);

// File: tb/tagged_arith_bench.sv
`timescale 1ns/1ps
module tagged_arith_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_sub = 1'b0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic        res_valid, cc_we, trap;
  logic [31:0] res_data;
  logic [3:0]  flags;

  int tests = 0;
  int fails = 0;
  logic [3:0]  m_flags = 4'b0;
  logic [31:0] m_data = '0;

  always #4 clk = ~clk;

  tagged_arith u_tagged_arith (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sub(op_sub),
    .opa(opa), .opb(opb), .res_valid(res_valid), .res_data(res_data),
    .cc_we(cc_we), .flags(flags), .trap(trap)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(bit v, bit sub, logic [31:0] a, logic [31:0] b, string req);
    longint sa, sb, sr, ua, ub;
    bit tagf, ovf, cy, e_ok, e_trap;
    logic [31:0] r;
    @(negedge clk);
    op_valid = v; op_sub = sub; opa = a; opb = b;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ua = longint'(a); ub = longint'(b);
    sr = sub ? sa - sb : sa + sb;
    r = sr[31:0];
    ovf = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    tagf = ((a | b) & 32'd3) != 0;
    cy = sub ? (ua < ub) : ((ua + ub) > 64'h0000_0000_FFFF_FFFF);
    e_trap = v && (tagf || ovf);
    e_ok = v && !e_trap;
    if (e_ok) begin
      m_data = r;
      m_flags = {r[31], (r == 0), 1'b0, cy};
    end
    @(posedge clk); #1;
    op_valid = 1'b0;
    chk(req, "trap", 32'(trap), 32'(e_trap));
    chk(req, "res_valid", 32'(res_valid), 32'(e_ok));
    chk(req, "cc_we", 32'(cc_we), 32'(e_ok));
    chk(req, "flags", 32'(flags), 32'(m_flags));
    chk(req, "res_data", res_data, m_data);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "res_valid", 32'(res_valid), 0);
    chk("R1", "trap", 32'(trap), 0);
    chk("R1", "cc_we", 32'(cc_we), 0);
    chk("R1", "flags", 32'(flags), 0);
    chk("R1", "res_data", res_data, 0);
    @(negedge clk); rst_n = 1'b1;

    step(0, 0, 32'h0000_0004, 32'h0000_0008, "R10");
    step(1, 0, 32'h0000_0004, 32'h0000_0008, "R2");
    step(1, 0, 32'hFFFF_FFFC, 32'h0000_0004, "R8");
    step(1, 0, 32'h8000_0000, 32'hFFFF_FFFC, "R5");
    step(1, 0, 32'h7FFF_FFFC, 32'h0000_0004, "R5");
    step(1, 0, 32'h7FFF_FFF8, 32'h0000_0004, "R9");
    step(1, 0, 32'hF000_0000, 32'h2000_0000, "R9");
    step(1, 1, 32'h0000_0010, 32'h0000_0004, "R3");
    step(1, 1, 32'h0000_0004, 32'h0000_0010, "R9");
    step(1, 1, 32'h0000_0020, 32'h0000_0020, "R8");
    step(1, 1, 32'h8000_0000, 32'h0000_0004, "R6");
    step(1, 1, 32'h7FFF_FFFC, 32'hFFFF_FFFC, "R6");
    step(1, 1, 32'h8000_0004, 32'h0000_0004, "R3");
    step(0, 1, 32'h0000_0001, 32'h0000_0000, "R10");
    step(1, 0, 32'h0000_0001, 32'h0000_0000, "R4");
    step(1, 0, 32'h0000_0000, 32'h0000_0002, "R4");
    step(1, 1, 32'h0000_0102, 32'h0000_0100, "R7");
    step(1, 1, 32'h0000_0100, 32'h0000_0003, "R7");
    step(1, 0, 32'h7FFF_FFFF, 32'h0000_0004, "R11");
    step(0, 0, 32'h0, 32'h0, "R11");
    step(1, 1, 32'h8000_0000, 32'h0000_0001, "R11");
    for (int i = 0; i < 40; i++) begin
      logic [31:0] a, b;
      a = 32'h9E37_79B9 * (i + 1);
      b = 32'h7F4A_7C15 ^ (a << 3);
      if (i % 3 != 0) begin a[1:0] = 2'b00; b[1:0] = 2'b00; end
      step(1, i[0], a, b, "R10");
    end
    step(0, 0, 32'h0, 32'h0, "R10");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule